// File: doc/BRIEF.md
# Saturating Echo Mixer with Feedback

This block performs the per-sample arithmetic of a three-tap digital echo. Once per sample period a start pulse presents an undelayed (dry) sample together with three samples read from a delay memory. Each delayed sample is scaled by its own depth gain, and the scaled values are added to the dry sample to form the effect output. In the same operation the block forms the sample to write back into the delay memory: the dry sample plus a feedback-scaled share of the previous effect output. The feedback gain therefore sets how fast the echoes die away.

Samples are signed 16-bit two's complement. Gains are unsigned 16-bit fractions in which the value g means g/65536. All additions are carried out at a wider precision and clamped once per result at the signed 16-bit limits, so a loud mix holds at full scale and never wraps. The result is ready three clock edges after start, far within any audio sample period. The delay memory and its addressing are outside this block.

Top module: `echo_mixer`

## Requirements
- R1: While reset is asserted and after it is released, mixOut and storeOut read 0 and mixValid and storeValid read 0.
- R2: When start is sampled high at a rising edge while the block is idle, mixOut, storeOut, mixValid and storeValid update at the second rising edge after it. Both valid flags are high for exactly one cycle.
- R3: A start sampled while an operation is in progress is ignored. No extra valid pulse appears, and the results come from the inputs captured with the accepted start.
- R4: Tap k occupies bits [16k+15:16k] of tapBus, and its gain occupies the same bits of gainBus. The scaled tap is floor(tap * gain / 65536), with the tap signed and the gain unsigned.
- R5: mixOut equals dryIn plus the sum of the three scaled taps, clamped to the signed 16-bit range.
- R6: A mix sum above +32767 gives mixOut = +32767 (0x7FFF).
- R7: A mix sum below -32768 gives mixOut = -32768 (0x8000).
- R8: storeOut equals dryIn plus floor(prevMix * fbGain / 65536), clamped to the signed 16-bit range. prevMix is the mixOut of the previous completed operation, or 0 if none has completed since reset.
- R9: Between valid pulses, mixOut and storeOut hold their values, whatever the data inputs do.
- R10: With all three gains at 0, mixOut equals dryIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins one mix operation when idle |
| dryIn | input | 16 | Undelayed input sample, signed |
| tapBus | input | 48 | Three delayed samples, tap k at bits [16k+15:16k] |
| gainBus | input | 48 | Three unsigned depth gains, same packing as tapBus |
| fbGain | input | 16 | Unsigned feedback gain |
| mixOut | output | 16 | Clamped effect output sample |
| mixValid | output | 1 | One-cycle pulse when mixOut is new |
| storeOut | output | 16 | Clamped sample to write into the delay memory |
| storeValid | output | 1 | One-cycle pulse when storeOut is new |

## Verification
Every result is due at the second rising edge after the edge that accepts start. The input edge is E0, the product registers load at E1 and the outputs load at E2. The directed tasks change inputs and raise start on falling edges. They read the outputs on the falling edge after E0, after E1, after E2 and after E3. Valid must be low, low, high and low at those points, and the data is compared only in the cycle after E2. The bench tracks the previous mix result itself, so the feedback term of each store value follows from its own earlier expectation.

// File: rtl/echo_mix_pkg.sv
package echo_mix_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_OUT  = 2'd2
  } mixState_t;

  typedef struct packed {
    logic capture;
    logic compute;
    logic publish;
  } ctrlStrobes_t;

endpackage

// File: rtl/echo_mix_ctrl.sv
module echo_mix_ctrl
  import echo_mix_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strb,
  output logic         busy
);

  mixState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = ST_MUL;
      ST_MUL:  stateNext = ST_OUT;
      ST_OUT:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.capture = start && (state == ST_IDLE);
    strb.compute = (state == ST_MUL);
    strb.publish = (state == ST_OUT);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/echo_mix_dp.sv
module echo_mix_dp
  import echo_mix_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 16,
  parameter int NUM_TAPS = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 strb,
  input  logic [SAMPLE_W-1:0]          dryIn,
  input  logic [NUM_TAPS*SAMPLE_W-1:0] tapBus,
  input  logic [NUM_TAPS*GAIN_W-1:0]   gainBus,
  input  logic [GAIN_W-1:0]            fbGain,
  output logic [SAMPLE_W-1:0]          mixOut,
  output logic [SAMPLE_W-1:0]          storeOut,
  output logic                         outValid
);

  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam int TERM_W = SAMPLE_W + 1;
  localparam int ACC_W  = SAMPLE_W + $clog2(NUM_TAPS + 1) + 1;

  logic [SAMPLE_W-1:0] dryQ;
  logic [SAMPLE_W-1:0] tapQ  [NUM_TAPS];
  logic [GAIN_W-1:0]   gainQ [NUM_TAPS];
  logic [GAIN_W-1:0]   fbQ;
  logic [TERM_W-1:0]   termQ [NUM_TAPS];
  logic [TERM_W-1:0]   fbTermQ;
  logic [ACC_W-1:0]    mixAcc, storeAcc;
  logic [SAMPLE_W-1:0] mixQ, storeQ;
  logic                validQ;

  function automatic logic [ACC_W-1:0] extendTerm(input logic [TERM_W-1:0] v);
    return {{(ACC_W-TERM_W){v[TERM_W-1]}}, v};
  endfunction

  function automatic logic [ACC_W-1:0] extendSample(input logic [SAMPLE_W-1:0] v);
    return {{(ACC_W-SAMPLE_W){v[SAMPLE_W-1]}}, v};
  endfunction

  function automatic logic [SAMPLE_W-1:0] clampSample(input logic [ACC_W-1:0] a);
    logic [ACC_W-SAMPLE_W:0] upper;
    upper = a[ACC_W-1:SAMPLE_W-1];
    if ((&upper) || !(|upper)) return a[SAMPLE_W-1:0];
    else if (a[ACC_W-1])       return {1'b1, {(SAMPLE_W-1){1'b0}}};
    else                       return {1'b0, {(SAMPLE_W-1){1'b1}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dryQ <= '0;
      fbQ  <= '0;
      for (int i = 0; i < NUM_TAPS; i++) begin
        tapQ[i]  <= '0;
        gainQ[i] <= '0;
      end
    end else if (strb.capture) begin
      dryQ <= dryIn;
      fbQ  <= fbGain;
      for (int i = 0; i < NUM_TAPS; i++) begin
        tapQ[i]  <= tapBus[i*SAMPLE_W +: SAMPLE_W];
        gainQ[i] <= gainBus[i*GAIN_W +: GAIN_W];
      end
    end
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    logic signed [PROD_W-1:0] prod;
    assign prod = $signed(tapQ[g]) * $signed({1'b0, gainQ[g]});
    always_ff @(posedge clk) begin
      if (!rstN)             termQ[g] <= '0;
      else if (strb.compute) termQ[g] <= prod[PROD_W-1:GAIN_W];
    end
  end

  logic signed [PROD_W-1:0] fbProd;
  assign fbProd = $signed(mixQ) * $signed({1'b0, fbQ});

  always_ff @(posedge clk) begin
    if (!rstN)             fbTermQ <= '0;
    else if (strb.compute) fbTermQ <= fbProd[PROD_W-1:GAIN_W];
  end

  always_comb begin
    mixAcc = extendSample(dryQ);
    for (int i = 0; i < NUM_TAPS; i++) mixAcc = mixAcc + extendTerm(termQ[i]);
    storeAcc = extendSample(dryQ) + extendTerm(fbTermQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mixQ   <= '0;
      storeQ <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.publish;
      if (strb.publish) begin
        mixQ   <= clampSample(mixAcc);
        storeQ <= clampSample(storeAcc);
      end
    end
  end

  assign mixOut   = mixQ;
  assign storeOut = storeQ;
  assign outValid = validQ;

endmodule

// File: rtl/echo_mixer.sv
module echo_mixer
  import echo_mix_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 16,
  parameter int NUM_TAPS = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [SAMPLE_W-1:0]          dryIn,
  input  logic [NUM_TAPS*SAMPLE_W-1:0] tapBus,
  input  logic [NUM_TAPS*GAIN_W-1:0]   gainBus,
  input  logic [GAIN_W-1:0]            fbGain,
  output logic [SAMPLE_W-1:0]          mixOut,
  output logic                         mixValid,
  output logic [SAMPLE_W-1:0]          storeOut,
  output logic                         storeValid
);

  ctrlStrobes_t strb;
  logic         busy;
  logic         outValid;

  echo_mix_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy)
  );

  echo_mix_dp #(
    .SAMPLE_W (SAMPLE_W),
    .GAIN_W   (GAIN_W),
    .NUM_TAPS (NUM_TAPS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dryIn    (dryIn),
    .tapBus   (tapBus),
    .gainBus  (gainBus),
    .fbGain   (fbGain),
    .mixOut   (mixOut),
    .storeOut (storeOut),
    .outValid (outValid)
  );

  assign mixValid   = outValid;
  assign storeValid = outValid;

endmodule

// File: rtl/echo_mixer_chk.sv
module echo_mixer_chk #(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 16,
  parameter int NUM_TAPS = 3
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         start,
  input logic                         busy,
  input logic [SAMPLE_W-1:0]          dryIn,
  input logic [NUM_TAPS*GAIN_W-1:0]   gainBus,
  input logic [GAIN_W-1:0]            fbGain,
  input logic [SAMPLE_W-1:0]          mixOut,
  input logic [SAMPLE_W-1:0]          storeOut,
  input logic                         mixValid
);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> ##2 mixValid);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    mixValid |=> !mixValid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !mixValid |-> ($stable(mixOut) && $stable(storeOut)));

  a_r10_zero_gain: assert property (@(posedge clk) disable iff (!rstN)
    ($past(start && !busy, 3) && $past(gainBus == '0, 3)) |-> (mixOut == $past(dryIn, 3)));

  a_r8_zero_feedback: assert property (@(posedge clk) disable iff (!rstN)
    ($past(start && !busy, 3) && $past(fbGain == '0, 3)) |-> (storeOut == $past(dryIn, 3)));

endmodule

bind echo_mixer echo_mixer_chk #(
  .SAMPLE_W (SAMPLE_W),
  .GAIN_W   (GAIN_W),
  .NUM_TAPS (NUM_TAPS)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .dryIn    (dryIn),
  .gainBus  (gainBus),
  .fbGain   (fbGain),
  .mixOut   (mixOut),
  .storeOut (storeOut),
  .mixValid (mixValid)
);

// File: tb/echo_mixer_tb_top.sv
module echo_mixer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] dryIn = '0;
  logic [47:0] tapBus = '0;
  logic [47:0] gainBus = '0;
  logic [15:0] fbGain = '0;
  logic [15:0] mixOut, storeOut;
  logic        mixValid, storeValid;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  longint prevMix = 0;

  always #5 clk = ~clk;

  echo_mixer dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .dryIn      (dryIn),
    .tapBus     (tapBus),
    .gainBus    (gainBus),
    .fbGain     (fbGain),
    .mixOut     (mixOut),
    .mixValid   (mixValid),
    .storeOut   (storeOut),
    .storeValid (storeValid)
  );

  function automatic longint sat16(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint scale(input longint s, input longint g);
    return (s * g) >>> 16;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int d, input int t0, input int t1, input int t2,
                       input int g0, input int g1, input int g2, input int fb);
    dryIn   = 16'(d);
    tapBus  = {16'(t2), 16'(t1), 16'(t0)};
    gainBus = {16'(g2), 16'(g1), 16'(g0)};
    fbGain  = 16'(fb);
  endtask

  // One operation: start accepted at E0, outputs due at E2.
  task automatic runOp(input string req, input int d, input int t0, input int t1, input int t2,
                       input int g0, input int g1, input int g2, input int fb);
    longint expMix, expStore;
    expMix = sat16(longint'(d) + scale(t0, g0) + scale(t1, g1) + scale(t2, g2));
    expStore = sat16(longint'(d) + scale(prevMix, fb));
    @(negedge clk);
    drive(d, t0, t1, t2, g0, g1, g2, fb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drive(-7, 111, 222, 333, 5, 6, 7, 8);
    check({req, " R2 valid low after E0"}, mixValid, 0);
    @(negedge clk);
    check({req, " R2 valid low after E1"}, mixValid, 0);
    @(negedge clk);
    check({req, " R2 mixValid after E2"}, mixValid, 1);
    check({req, " R2 storeValid after E2"}, storeValid, 1);
    check({req, " mixOut"}, longint'($signed(mixOut)), expMix);
    check({req, " R8 storeOut"}, longint'($signed(storeOut)), expStore);
    @(negedge clk);
    check({req, " R2 valid single cycle"}, mixValid, 0);
    prevMix = expMix;
  endtask

  task automatic testReset();
    check("R1 mixOut reset", mixOut, 0);
    check("R1 storeOut reset", storeOut, 0);
    check("R1 mixValid reset", mixValid, 0);
    check("R1 storeValid reset", storeValid, 0);
  endtask

  task automatic testZeroGain();
    runOp("R10 zero gains", 1234, 9000, -9000, 20000, 0, 0, 0, 0);
  endtask

  task automatic testBasic();
    runOp("R4 R5 mixed taps", 1000, 8000, -4000, 2000, 32768, 16384, 65535, 32768);
    runOp("R4 negative floor", -3, -1, -3, 5, 65535, 1, 40000, 1000);
  endtask

  task automatic testClampHigh();
    runOp("R6 positive clamp", 30000, 30000, 30000, 30000, 65535, 65535, 65535, 65535);
  endtask

  task automatic testClampLow();
    runOp("R7 negative clamp", -30000, -32768, -32768, -32768, 65535, 65535, 65535, 65535);
    runOp("R8 store clamp low", -100, 0, 0, 0, 0, 0, 0, 65535);
  endtask

  task automatic testBusyIgnore();
    longint expMix, expStore;
    int pulses;
    expMix = sat16(500 + scale(1000, 65535) + scale(-2000, 32768) + scale(4000, 16384));
    expStore = sat16(500 + scale(prevMix, 20000));
    @(negedge clk);
    drive(500, 1000, -2000, 4000, 65535, 32768, 16384, 20000);
    start = 1'b1;
    @(negedge clk);
    drive(-20000, -20000, -20000, -20000, 65535, 65535, 65535, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R3 accepted op valid", mixValid, 1);
    check("R3 mixOut from first inputs", longint'($signed(mixOut)), expMix);
    check("R3 storeOut from first inputs", longint'($signed(storeOut)), expStore);
    pulses = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (mixValid) pulses++;
    end
    check("R3 no extra pulse", pulses, 0);
    prevMix = expMix;
  endtask

  task automatic testHold();
    logic [15:0] m, s;
    m = mixOut;
    s = storeOut;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      drive(i * 777, -i * 999, 3000, 12, 65535, 65535, 65535, 65535);
    end
    check("R9 mixOut held", mixOut, m);
    check("R9 storeOut held", storeOut, s);
    check("R9 no valid", mixValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroGain();
    testBasic();
    testClampHigh();
    testClampLow();
    testBusyIgnore();
    testHold();
    runOp("R8 feedback chain", 0, 0, 0, 0, 0, 0, 0, 65535);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule